// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a simple on-chip write port and an external asynchronous static RAM with a 20-bit word address and a 16-bit data path. A requester raises a request with an address, a data word and two active-high byte enables. The block captures them and runs one write cycle on the memory pins. It then pulses an acknowledge for one clock. Every phase of the cycle is a whole number of clocks. The counts are derived at elaboration time from the clock period, the selected speed grade and whether the board ties the memory's output enable low.

The write window on the memory is the overlap of four conditions:
- the active-low chip select is low;
- the active-high chip select is high;
- at least one byte enable is low;
- write enable is low.

The sequencer opens the window by lowering write enable last, after a one-cycle setup phase. It closes the window by raising write enable first, then holds address, data and selects for one more cycle. The data bus is presented as an output value plus a drive-enable for the pad. The drive-enable is on from the setup phase through the hold phase. A request whose byte enables are both clear is acknowledged without touching the memory.

Top module: `sram_write_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, the chip selects are inactive (`sram_cs1_n`=1, `sram_cs2`=0), `sram_we_n`=1, both byte-enable pins are 1, `sram_dq_oe`=0 and `wr_ack`=0.
- R2: `sram_we_n` is low only while both chip selects are active and at least one byte-enable pin is low. `sram_ub_n` equals the inverse of `wr_be[1]` (data bits 15:8) and `sram_lb_n` equals the inverse of `wr_be[0]` (data bits 7:0) while the selects are active. Both byte-enable pins are high otherwise.
- R3: Selects, byte enables, address and data appear exactly one clock before `sram_we_n` falls. This is the clock that follows the edge accepting the request.
- R4: `sram_we_n` stays low for one unbroken run of P clocks. P is the smallest count that covers all of the following:
  - the write pulse minimum (18 ns fast, 30 ns slow);
  - the data setup minimum (12 ns fast, 15 ns slow);
  - when output enable is tied low, strictly more than the bus turn-off time plus the data setup (12+12 ns fast, 20+15 ns slow).

  P is then lengthened if needed so that setup plus pulse covers the address lead (15/25 ns) and the select and byte-enable lead (18/25 ns). P is never less than one.
- R5: `sram_we_n` rises one clock before the selects and byte enables go inactive. Address and data remain unchanged through that hold clock.
- R6: The span from the first clock with selects active to the clock before `wr_ack` covers the write cycle time (25 ns fast, 35 ns slow). Padding clocks with the memory deselected are inserted when setup, pulse and hold alone fall short.
- R7: `sram_dq_oe` is high in exactly the clocks where the chip selects are active, and low in all others.
- R8: With output enable not tied low (the default), `sram_oe_n` is held high at all times.
- R9: `wr_ack` is high for one clock per accepted request. Address, data, byte-enable and request inputs are ignored from acceptance until after `wr_ack`. A request held high across `wr_ack` starts a new cycle only after one idle clock.
- R10: A request with `wr_be`=2'b00 is acknowledged one clock after acceptance. Selects, byte enables, write enable and the data drive all stay inactive.
- R11: While selects are active, `sram_addr` and `sram_dq_o` equal the address and data present at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request, held until acknowledged |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte, active high |
| wr_ack | output | 1 | One-clock completion pulse |
| sram_addr | output | 20 | Memory address pins |
| sram_dq_o | output | 16 | Value driven onto the memory data bus |
| sram_dq_oe | output | 1 | Data bus pad drive enable, active high |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write enable |
| sram_ub_n | output | 1 | Active-low upper byte enable |
| sram_lb_n | output | 1 | Active-low lower byte enable |
| sram_oe_n | output | 1 | Active-low memory output enable |

## Verification
The hardest case to reach from the ports is a requester that misbehaves while a cycle is in flight. The bench provokes it directly: after acceptance it drives the complement of the address, data and byte enables on every clock, and it keeps the request raised through the acknowledge. The pins must still carry the captured values, and the next cycle must start only after an idle clock. All four byte-enable patterns are swept against boundary and alternating addresses and data. For each write, the bench counts the positions and lengths of the select, write-enable and drive windows. These are compared with phase counts the bench computes from the nanosecond minimums and the 4 ns period.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    // Sequencer states; order is not decoded anywhere outside the sequencer.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_PAD   = 3'd4,
        ST_ACK   = 3'd5
    } wr_state_e;

    // Memory minimum times in picoseconds, index 0 = fast grade, 1 = slow grade.
    localparam int unsigned T_CYCLE_PS  [2] = '{25000, 35000};
    localparam int unsigned T_WEPULSE_PS[2] = '{18000, 30000};
    localparam int unsigned T_ADDRLEAD_PS[2] = '{15000, 25000};
    localparam int unsigned T_SELLEAD_PS[2] = '{18000, 25000};
    localparam int unsigned T_DATALEAD_PS[2] = '{12000, 15000};
    localparam int unsigned T_BUSOFF_PS [2] = '{12000, 20000};

    // Fixed phase lengths: address may change with the select edge, hold of one clock.
    localparam int unsigned SETUP_CYCLES = 1;
    localparam int unsigned HOLD_CYCLES  = 1;

    // Whole clocks covering a time, never less than one.
    function automatic int unsigned span_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        if (n == 0) n = 1;
        return n;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Write-enable low length in clocks for a grade, period and output-enable wiring.
    function automatic int unsigned pulse_cycles(input int unsigned grade,
                                                 input int unsigned clk_ps,
                                                 input bit oe_tied_low);
        int unsigned g;
        int unsigned p;
        int unsigned lead;
        g = (grade == 0) ? 0 : 1;
        p = max_u(span_cycles(T_WEPULSE_PS[g], clk_ps),
                  span_cycles(T_DATALEAD_PS[g], clk_ps));
        if (oe_tied_low)
            p = max_u(p, span_cycles(T_BUSOFF_PS[g] + T_DATALEAD_PS[g] + 1, clk_ps));
        lead = max_u(span_cycles(T_ADDRLEAD_PS[g], clk_ps),
                     span_cycles(T_SELLEAD_PS[g], clk_ps));
        if (p + SETUP_CYCLES < lead) p = lead - SETUP_CYCLES;
        return p;
    endfunction

    // Deselected padding clocks needed to reach the full write cycle time.
    function automatic int unsigned pad_cycles(input int unsigned grade,
                                               input int unsigned clk_ps,
                                               input bit oe_tied_low);
        int unsigned g;
        int unsigned used;
        int unsigned need;
        g = (grade == 0) ? 0 : 1;
        used = SETUP_CYCLES + pulse_cycles(grade, clk_ps, oe_tied_low) + HOLD_CYCLES;
        need = span_cycles(T_CYCLE_PS[g], clk_ps);
        return (need > used) ? need - used : 0;
    endfunction

endpackage

// File: rtl/sram_wr_phase_timer.sv
// Phase timer: a down counter that is loaded with (length - 1) when the
// sequencer enters a phase and reports expiry when it reaches zero.
// Assumes load is asserted only on the clock a new phase is entered.
module sram_wr_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining clocks of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_seq.sv
// Write sequencer: walks idle -> setup -> pulse -> hold -> (pad) -> ack,
// or idle -> ack directly when no byte lane is enabled. Phase lengths are
// parameters; the phase timer tells it when a phase is over.
// Assumes wr_req is sampled only in idle, so a busy sequencer ignores it.
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 5,
    parameter int HOLD_CYC  = 1,
    parameter int PAD_CYC   = 0,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [1:0]       wr_be,
    input  logic             expired,
    output wr_state_e        state_q,
    output wr_state_e        state_d,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    localparam int SETUP_LD = (SETUP_CYC > 0) ? SETUP_CYC - 1 : 0;
    localparam int PULSE_LD = (PULSE_CYC > 0) ? PULSE_CYC - 1 : 0;
    localparam int HOLD_LD  = (HOLD_CYC  > 0) ? HOLD_CYC  - 1 : 0;
    localparam int PAD_LD   = (PAD_CYC   > 0) ? PAD_CYC   - 1 : 0;
    localparam bit HAS_PAD  = (PAD_CYC > 0);

    // Next-state decision from the current phase and timer expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_req) state_d = (wr_be == 2'b00) ? ST_ACK : ST_SETUP;
            ST_SETUP: if (expired) state_d = ST_PULSE;
            ST_PULSE: if (expired) state_d = ST_HOLD;
            ST_HOLD:  if (expired) state_d = HAS_PAD ? ST_PAD : ST_ACK;
            ST_PAD:   if (expired) state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Reload the timer with the length of whichever phase is being entered.
    always_comb begin
        load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP: load_val = CNT_W'(SETUP_LD);
            ST_PULSE: load_val = CNT_W'(PULSE_LD);
            ST_HOLD:  load_val = CNT_W'(HOLD_LD);
            ST_PAD:   load_val = CNT_W'(PAD_LD);
            default:  load_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/sram_wr_pins.sv
// Pin stage: captures the request on acceptance and registers every memory
// strobe from the sequencer's next state, so the pins change only on clock
// edges and line up with the sequencer's current state.
// Assumes DATA_W is even; the upper half is the upper byte lane.
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_state_e         state_q,
    input  wr_state_e         state_d,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_be,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n
);

    logic       capture;
    logic       sel_d;
    logic [1:0] be_q;
    logic [1:0] be_src;

    assign capture = (state_q == ST_IDLE) && (state_d == ST_SETUP);
    assign sel_d   = (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);
    assign be_src  = capture ? wr_be : be_q;

    // Hold the accepted address, data and lanes for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dq_o <= '0;
            be_q      <= '0;
        end else if (capture) begin
            sram_addr <= wr_addr;
            sram_dq_o <= wr_data;
            be_q      <= wr_be;
        end
    end

    // Register strobes and bus drive from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_cs1_n <= 1'b1;
            sram_cs2   <= 1'b0;
            sram_we_n  <= 1'b1;
            sram_ub_n  <= 1'b1;
            sram_lb_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_cs1_n <= ~sel_d;
            sram_cs2   <= sel_d;
            sram_we_n  <= ~(state_d == ST_PULSE);
            sram_ub_n  <= ~(sel_d & be_src[1]);
            sram_lb_n  <= ~(sel_d & be_src[0]);
            sram_dq_oe <= sel_d;
        end
    end

endmodule

// File: rtl/sram_write_ctrl.sv
// Asynchronous SRAM write sequencer top. Derives setup, pulse, hold and
// padding clocks from the clock period, speed grade and output-enable wiring,
// then runs one timed write per acknowledged request.
// Assumes the clock period is short enough that the one-clock hold ends
// before the memory can turn its outputs on when output enable is tied low.
module sram_write_ctrl
    import sram_wr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter bit          OE_HELD_LOW   = 1'b0,
    parameter int          ADDR_W        = 20,
    parameter int          DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_be,
    output logic              wr_ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic              sram_oe_n
);

    localparam int SETUP_CYC = int'(SETUP_CYCLES);
    localparam int HOLD_CYC  = int'(HOLD_CYCLES);
    localparam int PULSE_CYC = int'(pulse_cycles(SPEED_GRADE, CLK_PERIOD_PS, OE_HELD_LOW));
    localparam int PAD_CYC   = int'(pad_cycles(SPEED_GRADE, CLK_PERIOD_PS, OE_HELD_LOW));
    localparam int MAX_PH    = (PULSE_CYC > PAD_CYC) ? PULSE_CYC : PAD_CYC;
    localparam int CNT_W     = $clog2(MAX_PH + 1) + 1;

    wr_state_e        state_q;
    wr_state_e        state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    sram_wr_seq #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .PAD_CYC   (PAD_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_be    (wr_be),
        .expired  (tmr_expired),
        .state_q  (state_q),
        .state_d  (state_d),
        .load     (tmr_load),
        .load_val (tmr_val)
    );

    sram_wr_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_wr_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .state_d    (state_d),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .sram_addr  (sram_addr),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_cs1_n (sram_cs1_n),
        .sram_cs2   (sram_cs2),
        .sram_we_n  (sram_we_n),
        .sram_ub_n  (sram_ub_n),
        .sram_lb_n  (sram_lb_n)
    );

    // Completion pulse straight from the registered state.
    assign wr_ack    = (state_q == ST_ACK);
    // Output enable follows the board option: held high unless tied low.
    assign sram_oe_n = ~OE_HELD_LOW;

endmodule

// File: rtl/sram_write_ctrl_chk.sv
// Checker for the SRAM write sequencer, bound into every instance.
module sram_write_ctrl_chk #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int PULSE_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_o,
    input logic              sram_dq_oe,
    input logic              sram_cs1_n,
    input logic              sram_cs2,
    input logic              sram_we_n,
    input logic              sram_ub_n,
    input logic              sram_lb_n
);

    logic [7:0] low_run;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!sram_we_n)
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs1_n && sram_cs2 && (!sram_ub_n || !sram_lb_n))); // R2
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (low_run == 8'(PULSE_CYC))); // R4
    AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs1_n && sram_we_n)); // R3
    AST_WE_UP_BEFORE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_cs1_n); // R5
    AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs1_n && $past(!sram_cs1_n)) |-> ($stable(sram_addr) && $stable(sram_dq_o))); // R11
    AST_DRIVE_MATCHES_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe == !sram_cs1_n); // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack); // R9
    AST_NO_SELECT_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (sram_cs1_n && !sram_cs2 && sram_we_n)); // R6

endmodule

bind sram_write_ctrl sram_write_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ack     (wr_ack),
    .sram_addr  (sram_addr),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .sram_cs1_n (sram_cs1_n),
    .sram_cs2   (sram_cs2),
    .sram_we_n  (sram_we_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n)
);

// File: tb/sram_write_ctrl_tb.sv
module sram_write_ctrl_tb;

    localparam int CLK_PS   = 4000;
    localparam int WE_MIN   = 18000;
    localparam int DS_MIN   = 12000;
    localparam int AW_MIN   = 15000;
    localparam int SEL_MIN  = 18000;
    localparam int WC_MIN   = 25000;

    function automatic int clks(input int t);
        return (t + CLK_PS - 1) / CLK_PS;
    endfunction

    function automatic int exp_pulse();
        int p;
        int lead;
        p = (clks(WE_MIN) > clks(DS_MIN)) ? clks(WE_MIN) : clks(DS_MIN);
        lead = (clks(AW_MIN) > clks(SEL_MIN)) ? clks(AW_MIN) : clks(SEL_MIN);
        if (p + 1 < lead) p = lead - 1;
        return p;
    endfunction

    function automatic int exp_pad();
        int used;
        used = 1 + exp_pulse() + 1;
        return (clks(WC_MIN) > used) ? clks(WC_MIN) - used : 0;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic        wr_ack;
    logic [19:0] sram_addr;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe, sram_cs1_n, sram_cs2, sram_we_n, sram_ub_n, sram_lb_n, sram_oe_n;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    sram_write_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .wr_req (wr_req), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_be (wr_be), .wr_ack (wr_ack),
        .sram_addr (sram_addr), .sram_dq_o (sram_dq_o), .sram_dq_oe (sram_dq_oe),
        .sram_cs1_n (sram_cs1_n), .sram_cs2 (sram_cs2), .sram_we_n (sram_we_n),
        .sram_ub_n (sram_ub_n), .sram_lb_n (sram_lb_n), .sram_oe_n (sram_oe_n)
    );

    always #2ns clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, 100000);
            finish_run();
        end
    end

    task automatic run_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] b,
                             input bit scramble, input bit keep_req);
        int ack_k = 0, n_sel = 0, first_sel = 0, last_sel = 0;
        int n_low = 0, first_low = 0, last_low = 0;
        int bad_drv = 0, bad_addr = 0, bad_data = 0, bad_be = 0, bad_oe = 0, bad_gate = 0;
        int P = exp_pulse();
        int PAD = exp_pad();
        bit sel;
        @(negedge clk);
        check(sram_cs1_n == 1'b1, "R9", "idle before accept", sram_cs1_n, 1);
        wr_req = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk);
            if (scramble) begin wr_addr = ~a; wr_data = ~d; wr_be = ~b; end
            sel = !sram_cs1_n;
            if (sram_cs2 != sel) bad_gate++;
            if (sel) begin
                n_sel++;
                if (first_sel == 0) first_sel = k;
                last_sel = k;
                if (sram_addr != a) bad_addr++;
                if (sram_dq_o != d) bad_data++;
                if (sram_ub_n != ~b[1] || sram_lb_n != ~b[0]) bad_be++;
            end else if (!sram_ub_n || !sram_lb_n) bad_be++;
            if (sram_dq_oe != sel) bad_drv++;
            if (!sram_oe_n) bad_oe++;
            if (!sram_we_n) begin
                n_low++;
                if (first_low == 0) first_low = k;
                last_low = k;
                if (!sel || (sram_ub_n && sram_lb_n)) bad_gate++;
            end
            if (wr_ack) begin
                ack_k = k;
                if (!keep_req) wr_req = 1'b0;
                break;
            end
        end
        if (b != 2'b00) begin
            check(ack_k == P + 3 + PAD, "R6", "ack clock", ack_k, P + 3 + PAD);
            check(ack_k - 1 >= clks(WC_MIN), "R6", "cycle time clocks", ack_k - 1, clks(WC_MIN));
            check(first_sel == 1 && first_low == 2, "R3", "setup position", first_low, 2);
            check(n_low == P && last_low - first_low + 1 == n_low, "R4", "pulse length", n_low, P);
            check(last_sel == last_low + 1, "R5", "hold after we rise", last_sel, last_low + 1);
            check(bad_addr == 0, scramble ? "R9" : "R11", "address mismatches", bad_addr, 0);
            check(bad_data == 0, scramble ? "R9" : "R11", "data mismatches", bad_data, 0);
        end else begin
            check(ack_k == 1, "R10", "skip ack clock", ack_k, 1);
            check(n_sel == 0 && n_low == 0, "R10", "strobes on skip", n_sel + n_low, 0);
        end
        check(bad_be == 0 && bad_gate == 0, "R2", "lane/window errors", bad_be + bad_gate, 0);
        check(bad_drv == 0, "R7", "drive mismatches", bad_drv, 0);
        check(bad_oe == 0, "R8", "oe_n low clocks", bad_oe, 0);
    endtask

    initial begin
        // R1: reset state, with a request pending during reset.
        wr_req = 1'b1; wr_addr = 20'hFFFFF; wr_data = 16'hFFFF; wr_be = 2'b11;
        repeat (4) @(negedge clk);
        check(sram_cs1_n && !sram_cs2 && sram_we_n, "R1", "strobes in reset",
              {sram_cs1_n, sram_cs2, sram_we_n}, 3'b101);
        check(sram_ub_n && sram_lb_n && !sram_dq_oe && !wr_ack, "R1", "lanes/drive in reset",
              {sram_ub_n, sram_lb_n, sram_dq_oe, wr_ack}, 4'b1100);
        wr_req = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sram_cs1_n && sram_we_n && !wr_ack, "R1", "idle after reset",
              {sram_cs1_n, sram_we_n, wr_ack}, 3'b110);

        // Sweep byte lanes against boundary and alternating addresses and data.
        for (int ai = 0; ai < 6; ai++) begin
            for (int bi = 0; bi < 4; bi++) begin
                logic [19:0] a;
                logic [15:0] d;
                case (ai)
                    0: a = 20'h00000;
                    1: a = 20'hFFFFF;
                    2: a = 20'h55555;
                    3: a = 20'hAAAAA;
                    4: a = 20'h00001 << (ai * 3 + bi);
                    default: a = 20'h80000 >> bi;
                endcase
                d = 16'hA5C3 ^ 16'(ai * 16'h1111) ^ 16'(bi << 7);
                run_write(a, d, 2'(bi), 1'b0, 1'b0);
            end
        end

        // R9: inputs scrambled every clock while busy.
        for (int bi = 0; bi < 4; bi++)
            run_write(20'h3C3C3 + 20'(bi), 16'h1234 ^ 16'(bi), 2'(bi), 1'b1, 1'b0);

        // R9: request held high across the acknowledge.
        run_write(20'h0F0F0, 16'hBEEF, 2'b11, 1'b0, 1'b1);
        @(negedge clk);
        check(sram_cs1_n && !wr_ack, "R9", "idle clock after ack",
              {sram_cs1_n, wr_ack}, 2'b10);
        @(negedge clk);
        check(!sram_cs1_n && sram_addr == 20'h0F0F0, "R9", "held request restarts",
              sram_addr, 20'h0F0F0);
        wr_req = 1'b0;
        for (int k = 0; k < 32 && !wr_ack; k++) @(negedge clk);
        check(wr_ack == 1'b1, "R9", "restarted cycle acked", wr_ack, 1);
        @(negedge clk);
        check(!wr_ack && sram_cs1_n, "R9", "back to idle", {wr_ack, sram_cs1_n}, 2'b01);

        finish_run();
    end

endmodule